// File: doc/BRIEF.md
# Working-Set Clock Frame Replacement Selector

This block chooses which physical page frame to give up when a new page must be brought in. The frames form a ring, and a clock hand walks that ring one frame per cycle. Each frame keeps a "recently used" flag and a time stamp. The time stamp records the virtual time at which the frame was last seen in use. A frame whose flag is set is given another chance: the hand clears the flag, stamps the frame with the current virtual time and moves on. A frame whose flag is clear is the victim once its age exceeds the working-set window. The age is the current virtual time minus the stamp, taken modulo 2^16.

Software or a fault handler raises `find_req` while the selector is idle. It holds `vtime` and `window` steady during the search and waits for the one-cycle `done` pulse, which comes with the chosen frame on `victim`. The surrounding memory system reports two kinds of event. A use of a frame goes on `use_valid`/`use_frame`. A page placed into a frame goes on `fill_valid`/`fill_frame`. Dirty-page writeback and per-process accounting are handled elsewhere.

Top module: `wsc_victim_sel`

## Requirements
- R1: While and after reset, `busy` and `done` are 0, `hand_pos` is 0, and every frame has a clear use flag and a time stamp of 0.
- R2: During a search the hand examines exactly one frame per cycle. A frame found with its use flag set has the flag cleared and its stamp set to `vtime`, and the hand moves to the next frame (index N-1 wraps to 0). `done` rises exactly as many cycles after the accepting edge as frames were examined.
- R3: The first examined frame that has a clear use flag and an age strictly greater than `window` ends the search as the victim. A frame whose age equals `window` does not qualify.
- R4: Age is `vtime` minus the stamp in 16-bit unsigned arithmetic with wraparound. For example, a stamp of 0xFFF0 at `vtime` 0x0005 has age 21.
- R5: If a full revolution of 16 examined frames finds no qualifying frame, the victim is the first frame examined in that revolution whose use flag was clear.
- R6: If every frame examined in the revolution had its use flag set, the victim is the frame where the hand stood when the search began.
- R7: When `done` pulses, `hand_pos` equals `victim` plus one, modulo 16.
- R8: A fill event sets the frame's use flag and stamps it with `vtime`. A use event sets the use flag and leaves the stamp unchanged. A flagged frame is passed over by the next search.
- R9: `done` is high for exactly one cycle per search, and `victim` holds its value until the next `done`. A `find_req` raised while `busy` is 1 is ignored and starts no second search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| find_req | input | 1 | Start a victim search (taken only when idle) |
| vtime | input | 16 | Current virtual time |
| window | input | 16 | Working-set window size |
| use_valid | input | 1 | A frame was used |
| use_frame | input | 4 | Index of the used frame |
| fill_valid | input | 1 | A page was installed into a frame |
| fill_frame | input | 4 | Index of the filled frame |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse: `victim` is valid |
| victim | output | 4 | Chosen frame |
| hand_pos | output | 4 | Current clock hand position |

## Verification
The cases that are hardest to reach from the ports are the two fallback paths. Each needs a whole revolution in which no frame qualifies: the "all flags set" case and the "none old enough" case. Directed sequences set these up by first flagging or filling every frame and then sweeping once with a zero window, which leaves all stamps equal. The next search then runs with a window equal to the common age, and then one less, which tests the strict comparison and, from a stamp near 0xFFF0, the wraparound. A seeded random mix of use, fill, time steps and searches follows. Every result is compared with a bench model of the ring.

// File: rtl/wsc_pkg.sv
package wsc_pkg;

    parameter int unsigned NFRAMES = 16;
    parameter int unsigned TIME_W  = 16;
    localparam int unsigned IDX_W  = (NFRAMES > 1) ? $clog2(NFRAMES) : 1;

    typedef logic [IDX_W-1:0]  frame_t;
    typedef logic [TIME_W-1:0] vtime_t;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_st_e;

    typedef struct packed {
        logic   used;
        vtime_t stamp;
    } frame_ent_t;

    typedef struct packed {
        logic   vld;
        frame_t idx;
    } cand_t;

    function automatic frame_t frame_next(input frame_t i);
        if (i == frame_t'(NFRAMES - 1))
            return '0;
        return i + frame_t'(1);
    endfunction

    function automatic vtime_t frame_age(input vtime_t now, input vtime_t stamp);
        return now - stamp;
    endfunction

endpackage

// File: rtl/wsc_frame_table.sv
module wsc_frame_table
    import wsc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  vtime_t              vtime,
    input  logic                scan_clr,
    input  frame_t              scan_idx,
    input  logic                use_valid,
    input  frame_t              use_frame,
    input  logic                fill_valid,
    input  frame_t              fill_frame,
    output frame_ent_t          cur_ent,
    output logic [NFRAMES-1:0]  used_bits
);

    frame_ent_t ents [NFRAMES];

    for (genvar g = 0; g < NFRAMES; g++) begin : g_frame
        localparam frame_t MY_IDX = frame_t'(g);
        always_ff @(posedge clk) begin
            if (rst) begin
                ents[g] <= '0;
            end else begin
                // Scan update first; external events to the same frame win.
                if (scan_clr && scan_idx == MY_IDX) begin
                    ents[g].used  <= 1'b0;
                    ents[g].stamp <= vtime;
                end
                if (use_valid && use_frame == MY_IDX)
                    ents[g].used <= 1'b1;
                if (fill_valid && fill_frame == MY_IDX) begin
                    ents[g].used  <= 1'b1;
                    ents[g].stamp <= vtime;
                end
            end
        end
        assign used_bits[g] = ents[g].used;
    end

    assign cur_ent = ents[scan_idx];

endmodule

// File: rtl/wsc_age_check.sv
module wsc_age_check
    import wsc_pkg::*;
(
    input  frame_ent_t ent,
    input  vtime_t     vtime,
    input  vtime_t     window,
    output logic       referenced,
    output logic       expired
);

    vtime_t age;

    always_comb begin
        age        = frame_age(vtime, ent.stamp);
        referenced = ent.used;
        expired    = !ent.used && (age > window);
    end

endmodule

// File: rtl/wsc_scan_ctrl.sv
module wsc_scan_ctrl
    import wsc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   find_req,
    input  logic   cur_referenced,
    input  logic   cur_expired,
    output logic   scan_clr,
    output frame_t hand,
    output logic   busy,
    output logic   done,
    output frame_t victim
);

    scan_st_e state;
    frame_t   start_idx;
    frame_t   step_cnt;
    cand_t    cand;

    logic     last_step;
    logic     finish;
    frame_t   pick;

    always_comb begin
        last_step = (step_cnt == frame_t'(NFRAMES - 1));
        scan_clr  = (state == ST_SCAN) && cur_referenced;
        finish    = (state == ST_SCAN) && (cur_expired || last_step);
        if (cur_expired)
            pick = hand;
        else if (cand.vld)
            pick = cand.idx;
        else if (!cur_referenced)
            pick = hand;
        else
            pick = start_idx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            hand      <= '0;
            start_idx <= '0;
            step_cnt  <= '0;
            cand      <= '0;
            done      <= 1'b0;
            victim    <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (find_req) begin
                        state     <= ST_SCAN;
                        start_idx <= hand;
                        step_cnt  <= '0;
                        cand      <= '0;
                    end
                end
                ST_SCAN: begin
                    if (finish) begin
                        state  <= ST_IDLE;
                        done   <= 1'b1;
                        victim <= pick;
                        hand   <= frame_next(pick);
                    end else begin
                        hand     <= frame_next(hand);
                        step_cnt <= step_cnt + frame_t'(1);
                        if (!cand.vld && !cur_referenced) begin
                            cand.vld <= 1'b1;
                            cand.idx <= hand;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state == ST_SCAN);

endmodule

// File: rtl/wsc_victim_sel.sv
module wsc_victim_sel
    import wsc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 find_req,
    input  logic [TIME_W-1:0]    vtime,
    input  logic [TIME_W-1:0]    window,
    input  logic                 use_valid,
    input  logic [IDX_W-1:0]     use_frame,
    input  logic                 fill_valid,
    input  logic [IDX_W-1:0]     fill_frame,
    output logic                 busy,
    output logic                 done,
    output logic [IDX_W-1:0]     victim,
    output logic [IDX_W-1:0]     hand_pos
);

    frame_ent_t          cur_ent;
    logic [NFRAMES-1:0]  used_bits;
    logic                scan_clr;
    logic                cur_referenced;
    logic                cur_expired;
    frame_t              hand;

    wsc_frame_table u_table (
        .clk        (clk),
        .rst        (rst),
        .vtime      (vtime),
        .scan_clr   (scan_clr),
        .scan_idx   (hand),
        .use_valid  (use_valid),
        .use_frame  (use_frame),
        .fill_valid (fill_valid),
        .fill_frame (fill_frame),
        .cur_ent    (cur_ent),
        .used_bits  (used_bits)
    );

    wsc_age_check u_age (
        .ent        (cur_ent),
        .vtime      (vtime),
        .window     (window),
        .referenced (cur_referenced),
        .expired    (cur_expired)
    );

    wsc_scan_ctrl u_ctrl (
        .clk            (clk),
        .rst            (rst),
        .find_req       (find_req),
        .cur_referenced (cur_referenced),
        .cur_expired    (cur_expired),
        .scan_clr       (scan_clr),
        .hand           (hand),
        .busy           (busy),
        .done           (done),
        .victim         (victim)
    );

    assign hand_pos = hand;

endmodule

// File: rtl/wsc_victim_sel_chk.sv
module wsc_victim_sel_chk
    import wsc_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               busy,
    input logic               done,
    input frame_t             victim,
    input frame_t             hand_pos,
    input logic               fill_valid,
    input frame_t             fill_frame,
    input logic [NFRAMES-1:0] used_bits
);

    logic [IDX_W:0] busy_run;

    always_ff @(posedge clk) begin
        if (rst || !busy)
            busy_run <= '0;
        else
            busy_run <= busy_run + 1'b1;
    end

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (!busy && !done && hand_pos == '0 && used_bits == '0));

    p_hand_step_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> hand_pos == frame_next($past(hand_pos)));

    p_scan_bound_r2: assert property (@(posedge clk) disable iff (rst)
        busy_run <= (IDX_W+1)'(NFRAMES));

    p_hand_after_pick_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> hand_pos == frame_next(victim));

    p_fill_marks_r8: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && !busy) |=> used_bits[$past(fill_frame)]);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_end_with_done_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    p_victim_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!done && !$past(rst)) |-> $stable(victim));

endmodule

bind wsc_victim_sel wsc_victim_sel_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .done       (done),
    .victim     (victim),
    .hand_pos   (hand_pos),
    .fill_valid (fill_valid),
    .fill_frame (fill_frame),
    .used_bits  (used_bits)
);

// File: tb/tb_wsc_victim_sel.sv
module tb_wsc_victim_sel;

    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        find_req = 1'b0;
    logic [15:0] vtime = '0;
    logic [15:0] window = '0;
    logic        use_valid = 1'b0;
    logic [3:0]  use_frame = '0;
    logic        fill_valid = 1'b0;
    logic [3:0]  fill_frame = '0;
    logic        busy, done;
    logic [3:0]  victim, hand_pos;

    int checks = 0;
    int fails  = 0;

    // bench model of the ring
    bit          m_used  [N];
    logic [15:0] m_stamp [N];
    int          m_hand;

    always #2 clk = ~clk;

    wsc_victim_sel dut (
        .clk(clk), .rst(rst), .find_req(find_req), .vtime(vtime), .window(window),
        .use_valid(use_valid), .use_frame(use_frame),
        .fill_valid(fill_valid), .fill_frame(fill_frame),
        .busy(busy), .done(done), .victim(victim), .hand_pos(hand_pos)
    );

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_use(input int f);
        use_valid = 1'b1; use_frame = 4'(f);
        tick();
        use_valid = 1'b0;
        m_used[f] = 1'b1;
    endtask

    task automatic do_fill(input int f);
        fill_valid = 1'b1; fill_frame = 4'(f);
        tick();
        fill_valid = 1'b0;
        m_used[f]  = 1'b1;
        m_stamp[f] = vtime;
    endtask

    // model search: returns the pick and the number of frames examined
    task automatic model_find(output int pick, output int steps);
        int start = m_hand;
        int cand  = -1;
        pick  = -1;
        steps = N;
        for (int k = 0; k < N; k++) begin
            int idx = (start + k) % N;
            logic [15:0] age = vtime - m_stamp[idx];
            if (m_used[idx]) begin
                m_used[idx]  = 1'b0;
                m_stamp[idx] = vtime;
            end else if (age > window) begin
                pick  = idx;
                steps = k + 1;
                break;
            end else if (cand < 0) begin
                cand = idx;
            end
        end
        if (pick < 0) pick = (cand >= 0) ? cand : start;
        m_hand = (pick + 1) % N;
    endtask

    task automatic do_find(input string req, input logic [15:0] w, input bit poke);
        int exp_pick, exp_steps, n;
        window = w;
        model_find(exp_pick, exp_steps);
        find_req = 1'b1;
        tick();
        find_req = 1'b0;
        n = 0;
        while (!done && n < N + 4) begin
            if (poke && busy) find_req = 1'b1;
            tick();
            find_req = 1'b0;
            n++;
        end
        check(req, int'(victim), exp_pick, "victim");
        check("R2", n, exp_steps, "cycles to done");
        check("R7", int'(hand_pos), m_hand, "hand after pick");
        tick();
        check("R9", int'(done), 0, "done width");
        if (poke) begin
            check("R9", int'(busy), 0, "request while busy ignored");
            check("R9", int'(victim), exp_pick, "victim held");
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd4242));
        for (int i = 0; i < N; i++) begin m_used[i] = 0; m_stamp[i] = '0; end
        m_hand = 0;
        repeat (3) tick();
        check("R1", int'(busy), 0, "busy in reset");
        rst = 1'b0;
        tick();
        check("R1", int'(busy), 0, "busy after reset");
        check("R1", int'(done), 0, "done after reset");
        check("R1", int'(hand_pos), 0, "hand after reset");

        // R6: all flagged, no frame qualifies -> start frame
        for (int i = 0; i < N; i++) do_use(i);
        do_find("R6", 16'd0, 1'b0);
        // R5: none old enough -> first unflagged frame seen
        vtime = 16'd5;
        do_find("R5", 16'd10, 1'b0);
        // R3: immediate expiry
        vtime = 16'd20;
        do_find("R3", 16'd10, 1'b0);
        // R8: used frames are passed over
        do_use(m_hand);
        do_use((m_hand + 1) % N);
        do_find("R8", 16'd10, 1'b0);

        // R3 boundary: equal stamps, age == window is not old enough
        vtime = 16'd100;
        for (int i = 0; i < N; i++) do_fill(i);
        do_find("R8", 16'd0, 1'b0);
        vtime = 16'd103;
        do_find("R3", 16'd3, 1'b0);
        do_find("R3", 16'd2, 1'b0);

        // R4: wraparound age
        vtime = 16'hFFF0;
        for (int i = 0; i < N; i++) do_fill(i);
        do_find("R4", 16'd0, 1'b0);
        vtime = 16'h0005;
        do_find("R4", 16'd21, 1'b0);
        do_find("R4", 16'd20, 1'b0);

        // R9: request raised while busy
        for (int i = 0; i < N; i++) do_use(i);
        do_find("R9", 16'd0, 1'b1);

        // random mix
        for (int it = 0; it < 400; it++) begin
            int op = $urandom_range(0, 9);
            if (op < 3)       do_use($urandom_range(0, N - 1));
            else if (op < 5)  do_fill($urandom_range(0, N - 1));
            else if (op < 7)  vtime = vtime + 16'($urandom_range(0, 40));
            else              do_find("R3", 16'($urandom_range(0, 60)), ($urandom_range(0, 7) == 0));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule